// File: doc/BRIEF.md
# MII Receive Nibble Framer

This block sits between the decoding logic of a 10/100 Ethernet PHY and the media-independent interface toward a MAC. It takes one decoded nibble per receive clock, qualified by a carrier flag and a speed select. It then produces the receive data nibble and its frame-valid strobe. Both are launched on the falling clock edge, so they are settled when the MAC samples on the rising edge.

The framing rule depends on speed. At 100 Mb/s every nibble seen while carrier is up is passed as valid, preamble included. At 10 Mb/s the preamble is removed. The strobe first asserts on the low half of the start-of-frame delimiter, and the delimiter arrives low nibble first as 0x5 then 0xD. To tell that 0x5 apart from the preamble 0x5 nibbles ahead of it, the block holds every nibble for one clock before it decides. The same latency applies at both speeds.

A small transmit monitor shares the clock. It flags a frame whose transmit enable rises on a nibble other than the first preamble nibble 0x5.

Top module: `mii_rx_fmt`

## Requirements
- R1: Nibbles are 4 bits wide and leave in the order they arrived, one for one. The nibble sampled at rising edge n is launched on the falling edge that follows rising edge n+1.
- R2: With speed select high (100 Mb/s), every nibble sampled with carrier high is marked valid, including all preamble nibbles.
- R3: With speed select low (10 Mb/s), nibbles ahead of the delimiter pair (0x5 followed directly by 0xD, both with carrier high) are never marked valid. The strobe rises together with the 0x5 nibble of that pair.
- R4: At 10 Mb/s, once a frame has started, every later nibble with carrier high stays valid. Further 0x5/0xD pairs inside the frame change nothing.
- R5: A nibble sampled with carrier low is never marked valid. When carrier drops mid-frame, the strobe falls in the slot of the first carrier-low nibble. A delimiter pair split by a carrier drop does not start a frame.
- R6: The receive data output is zero whenever the strobe is low.
- R7: The receive outputs change only on the falling clock edge and hold still across the rising edge.
- R8: The transmit error output is high for exactly one clock after a rising edge at which transmit enable goes from 0 to 1 with transmit data other than 0x5. Otherwise it is low.
- R9: Reset (active low, asynchronous) forces all outputs low and clears the held nibble and framing state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive/transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spd100_i | input | 1 | 1 = 100 Mb/s framing, 0 = 10 Mb/s framing |
| car_i | input | 1 | Carrier present for the current nibble |
| nib_i | input | 4 | Decoded line nibble |
| rxd_o | output | 4 | Receive data nibble toward the MAC |
| rxdv_o | output | 1 | Receive frame-valid strobe |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| txd_i | input | 4 | Transmit data nibble from the MAC |
| tx_err_o | output | 1 | Transmit framing error pulse |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles, preamble nibble 0x5, delimiter high nibble 0xD, and the falling-edge launch variant. With that build, each output can be watched both just after the rising edge and just after the falling edge, which shows the half-cycle launch directly. It also drives the preamble/delimiter ambiguity at 10 Mb/s with real 0x5/0xD values: long preambles, a lone 0xD, a pair split by a carrier drop, and pairs repeated inside the payload. Those same default values make the one-cycle look-ahead and the 0x5 first-nibble rule of the transmit monitor observable.

// File: rtl/mii_rx_fmt_pkg.sv
`timescale 1ns/100ps
package mii_rx_fmt_pkg;

   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_FRAME = 1'b1
   } fmt_st_e;

   function automatic logic pair_hit(input logic [7:0] held, input logic [7:0] cur,
                                     input logic [7:0] lo, input logic [7:0] hi);
      return (held == lo) && (cur == hi);
   endfunction

endpackage

// File: rtl/mii_rx_hold.sv
`timescale 1ns/100ps
module mii_rx_hold #(
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          car_i,
   input  logic [DW-1:0] nib_i,
   output logic          h_car_o,
   output logic [DW-1:0] h_nib_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_car_o <= 1'b0;
         h_nib_o <= '0;
      end else begin
         h_car_o <= car_i;
         h_nib_o <= car_i ? nib_i : '0;
      end
   end

endmodule

// File: rtl/mii_rx_gate.sv
`timescale 1ns/100ps
module mii_rx_gate
   import mii_rx_fmt_pkg::*;
#(
   parameter int          DW      = 4,
   parameter logic [7:0]  PRE_NIB = 8'h5,
   parameter logic [7:0]  SFD_NIB = 8'hD
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spd100_i,
   input  logic          car_i,
   input  logic [DW-1:0] nib_i,
   input  logic          h_car_i,
   input  logic [DW-1:0] h_nib_i,
   output logic          dv_o,
   output logic [DW-1:0] dat_o
);

   localparam int PADW = 8 - DW;

   fmt_st_e       st_q, st_d;
   logic          dv_d;
   logic [DW-1:0] dat_d;
   logic [7:0]    held_w, cur_w;
   logic          start_w;

   assign held_w  = {{PADW{1'b0}}, h_nib_i};
   assign cur_w   = {{PADW{1'b0}}, nib_i};
   assign start_w = car_i && pair_hit(held_w, cur_w, PRE_NIB, SFD_NIB);

   always_comb begin
      st_d  = st_q;
      dv_d  = 1'b0;
      dat_d = '0;
      if (!h_car_i) begin
         st_d = ST_HUNT;
      end else if (spd100_i) begin
         dv_d  = 1'b1;
         dat_d = h_nib_i;
         st_d  = ST_FRAME;
      end else begin
         unique case (st_q)
            ST_HUNT: begin
               if (start_w) begin
                  dv_d  = 1'b1;
                  dat_d = h_nib_i;
                  st_d  = ST_FRAME;
               end
            end
            ST_FRAME: begin
               dv_d  = 1'b1;
               dat_d = h_nib_i;
            end
            default: st_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_HUNT;
         dv_o  <= 1'b0;
         dat_o <= '0;
      end else begin
         st_q  <= st_d;
         dv_o  <= dv_d;
         dat_o <= dat_d;
      end
   end

endmodule

// File: rtl/mii_rx_launch.sv
`timescale 1ns/100ps
module mii_rx_launch #(
   parameter int DW         = 4,
   parameter bit LAUNCH_FALL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dv_i,
   input  logic [DW-1:0] dat_i,
   output logic          dv_o,
   output logic [DW-1:0] dat_o
);

   generate
      if (LAUNCH_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dv_o  <= 1'b0;
               dat_o <= '0;
            end else begin
               dv_o  <= dv_i;
               dat_o <= dv_i ? dat_i : '0;
            end
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dv_o  <= 1'b0;
               dat_o <= '0;
            end else begin
               dv_o  <= dv_i;
               dat_o <= dv_i ? dat_i : '0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mii_tx_mon.sv
`timescale 1ns/100ps
module mii_tx_mon #(
   parameter int         DW      = 4,
   parameter logic [7:0] PRE_NIB = 8'h5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_en_i,
   input  logic [DW-1:0] txd_i,
   output logic          err_o
);

   localparam logic [DW-1:0] FIRST = PRE_NIB[DW-1:0];

   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         err_o <= 1'b0;
      end else begin
         en_q  <= tx_en_i;
         err_o <= tx_en_i && !en_q && (txd_i != FIRST);
      end
   end

endmodule

// File: rtl/mii_rx_fmt.sv
`timescale 1ns/100ps
module mii_rx_fmt #(
   parameter int         DW          = 4,
   parameter logic [7:0] PRE_NIB     = 8'h5,
   parameter logic [7:0] SFD_NIB     = 8'hD,
   parameter bit         LAUNCH_FALL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spd100_i,
   input  logic          car_i,
   input  logic [DW-1:0] nib_i,
   output logic [DW-1:0] rxd_o,
   output logic          rxdv_o,
   input  logic          tx_en_i,
   input  logic [DW-1:0] txd_i,
   output logic          tx_err_o
);

   generate
      if (DW < 2 || DW > 8) begin : g_bad_dw
         $error("mii_rx_fmt: DW must lie in 2..8");
      end
      if (PRE_NIB == SFD_NIB) begin : g_bad_pair
         $error("mii_rx_fmt: preamble and delimiter nibbles must differ");
      end
      if ((PRE_NIB >> DW) != 0 || (SFD_NIB >> DW) != 0) begin : g_bad_code
         $error("mii_rx_fmt: framing codes exceed DW bits");
      end
   endgenerate

   logic          h_car;
   logic [DW-1:0] h_nib;
   logic          g_dv;
   logic [DW-1:0] g_dat;

   mii_rx_hold #(.DW(DW)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .car_i   (car_i),
      .nib_i   (nib_i),
      .h_car_o (h_car),
      .h_nib_o (h_nib)
   );

   mii_rx_gate #(.DW(DW), .PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .spd100_i (spd100_i),
      .car_i    (car_i),
      .nib_i    (nib_i),
      .h_car_i  (h_car),
      .h_nib_i  (h_nib),
      .dv_o     (g_dv),
      .dat_o    (g_dat)
   );

   mii_rx_launch #(.DW(DW), .LAUNCH_FALL(LAUNCH_FALL)) u_launch (
      .clk   (clk),
      .rst_n (rst_n),
      .dv_i  (g_dv),
      .dat_i (g_dat),
      .dv_o  (rxdv_o),
      .dat_o (rxd_o)
   );

   mii_tx_mon #(.DW(DW), .PRE_NIB(PRE_NIB)) u_txmon (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en_i (tx_en_i),
      .txd_i   (txd_i),
      .err_o   (tx_err_o)
   );

endmodule

// File: rtl/mii_rx_fmt_chk.sv
`timescale 1ns/100ps
module mii_rx_fmt_chk #(
   parameter int         DW      = 4,
   parameter logic [7:0] PRE_NIB = 8'h5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          spd100_i,
   input logic          car_i,
   input logic [DW-1:0] rxd_o,
   input logic          rxdv_o,
   input logic          tx_en_i,
   input logic [DW-1:0] txd_i,
   input logic          tx_err_o
);

   localparam logic [DW-1:0] FIRST = PRE_NIB[DW-1:0];

   logic [1:0] age_q;
   logic       ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= 2'd0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end
   assign ok = (age_q == 2'd3);

   // R2
   fast_all_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && $past(spd100_i) && $past(car_i, 2)) |-> rxdv_o);

   // R5
   no_carrier_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && !$past(car_i, 2)) |-> !rxdv_o);

   // R6
   idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rxdv_o |-> (rxd_o == '0));

   // R3
   slow_start_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && !$past(spd100_i) && $rose(rxdv_o)) |-> (rxd_o == FIRST));

   // R8
   tx_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && tx_err_o) |-> ($past(tx_en_i) && !$past(tx_en_i, 2) && ($past(txd_i) != FIRST)));

   // R8
   tx_err_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && $past(tx_en_i) && !$past(tx_en_i, 2) && ($past(txd_i) != FIRST)) |-> tx_err_o);

endmodule

bind mii_rx_fmt mii_rx_fmt_chk #(.DW(DW), .PRE_NIB(PRE_NIB)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .spd100_i (spd100_i),
   .car_i    (car_i),
   .rxd_o    (rxd_o),
   .rxdv_o   (rxdv_o),
   .tx_en_i  (tx_en_i),
   .txd_i    (txd_i),
   .tx_err_o (tx_err_o)
);

// File: tb/mii_rx_fmt_tb.sv
`timescale 1ns/100ps
module mii_rx_fmt_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spd100_i = 1'b0;
   logic       car_i = 1'b0;
   logic [3:0] nib_i = '0;
   logic [3:0] rxd_o;
   logic       rxdv_o;
   logic       tx_en_i = 1'b0;
   logic [3:0] txd_i = '0;
   logic       tx_err_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mii_rx_fmt u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .spd100_i (spd100_i),
      .car_i    (car_i),
      .nib_i    (nib_i),
      .rxd_o    (rxd_o),
      .rxdv_o   (rxdv_o),
      .tx_en_i  (tx_en_i),
      .txd_i    (txd_i),
      .tx_err_o (tx_err_o)
   );

   // entry: {speed, carrier, nibble[3:0], expected valid, expected data[3:0]}
   // expected fields describe the nibble driven in the previous entry (R1 latency)
   localparam int NV = 29;
   localparam logic [10:0] VEC [NV] = '{
      {1'b1,1'b1,4'h5, 1'b0,4'h0},   // R2 100M preamble
      {1'b1,1'b1,4'h5, 1'b1,4'h5},
      {1'b1,1'b1,4'hD, 1'b1,4'h5},
      {1'b1,1'b1,4'hA, 1'b1,4'hD},
      {1'b1,1'b1,4'h3, 1'b1,4'hA},
      {1'b1,1'b0,4'h0, 1'b1,4'h3},   // R5 drop
      {1'b1,1'b0,4'h0, 1'b0,4'h0},
      {1'b0,1'b1,4'h5, 1'b0,4'h0},   // R3 10M preamble hidden
      {1'b0,1'b1,4'h5, 1'b0,4'h0},
      {1'b0,1'b1,4'h5, 1'b0,4'h0},
      {1'b0,1'b1,4'hD, 1'b1,4'h5},   // R3 start on 0x5
      {1'b0,1'b1,4'h7, 1'b1,4'hD},
      {1'b0,1'b1,4'h2, 1'b1,4'h7},
      {1'b0,1'b0,4'h0, 1'b1,4'h2},
      {1'b0,1'b0,4'h0, 1'b0,4'h0},
      {1'b0,1'b1,4'h5, 1'b0,4'h0},   // R5 split pair
      {1'b0,1'b0,4'hD, 1'b0,4'h0},
      {1'b0,1'b0,4'h0, 1'b0,4'h0},
      {1'b0,1'b1,4'hA, 1'b0,4'h0},   // R3 lone 0xD
      {1'b0,1'b1,4'hD, 1'b0,4'h0},
      {1'b0,1'b1,4'h5, 1'b0,4'h0},
      {1'b0,1'b1,4'hD, 1'b1,4'h5},
      {1'b0,1'b1,4'h5, 1'b1,4'hD},   // R4 repeat pair in payload
      {1'b0,1'b1,4'hD, 1'b1,4'h5},
      {1'b0,1'b1,4'hE, 1'b1,4'hD},
      {1'b0,1'b0,4'hE, 1'b1,4'hE},
      {1'b0,1'b0,4'h0, 1'b0,4'h0},   // R6 data zero
      {1'b1,1'b0,4'hF, 1'b0,4'h0},
      {1'b1,1'b0,4'hF, 1'b0,4'h0}
   };

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // drive now, pass one rising edge, look 0.5 ns after it and again after the falling edge
   task automatic step(input logic s, input logic c, input logic [3:0] n,
                       input logic te, input logic [3:0] td);
      logic       pdv;
      logic [3:0] pd;
      spd100_i = s; car_i = c; nib_i = n; tx_en_i = te; txd_i = td;
      pdv = rxdv_o; pd = rxd_o;
      @(posedge clk);
      #0.5;
      // R7: no change across the rising edge
      chk("R7", {1'b0, rxdv_o, rxd_o}, {1'b0, pdv, pd});
      #2.5;
   endtask

   initial begin
      #100000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #12;
      // R9 reset state
      chk("R9", {rxdv_o, tx_err_o, rxd_o}, 6'h0);
      @(posedge clk); #3;
      rst_n = 1'b1;
      step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0);
      step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0);

      // R1 R2 R3 R4 R5 R6 table walk
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][10], VEC[i][9], VEC[i][8:5], 1'b0, 4'h0);
         chk("R1/R2/R3/R4/R5 vector", {1'b0, rxdv_o, rxd_o}, {1'b0, VEC[i][4], VEC[i][3:0]});
      end

      // R8 transmit monitor
      step(1'b1, 1'b0, 4'h0, 1'b0, 4'h0);
      chk("R8 idle", {5'd0, tx_err_o}, 6'd0);
      step(1'b1, 1'b0, 4'h0, 1'b1, 4'h5);
      chk("R8 good start", {5'd0, tx_err_o}, 6'd0);
      step(1'b1, 1'b0, 4'h0, 1'b1, 4'h7);
      chk("R8 held enable", {5'd0, tx_err_o}, 6'd0);
      step(1'b1, 1'b0, 4'h0, 1'b0, 4'h0);
      chk("R8 end", {5'd0, tx_err_o}, 6'd0);
      step(1'b1, 1'b0, 4'h0, 1'b1, 4'hA);
      chk("R8 bad start", {5'd0, tx_err_o}, 6'd1);
      step(1'b1, 1'b0, 4'h0, 1'b1, 4'h5);
      chk("R8 single pulse", {5'd0, tx_err_o}, 6'd0);
      step(1'b1, 1'b0, 4'h0, 1'b0, 4'h0);

      // R9 reset mid-frame clears outputs and held state
      step(1'b1, 1'b1, 4'h9, 1'b0, 4'h0);
      step(1'b1, 1'b1, 4'h6, 1'b0, 4'h0);
      chk("R2 valid before reset", {1'b0, rxdv_o, rxd_o}, {1'b0, 1'b1, 4'h9});
      step(1'b0, 1'b1, 4'h5, 1'b0, 4'h0);
      rst_n = 1'b0;
      #1;
      chk("R9 async clear", {rxdv_o, tx_err_o, rxd_o}, 6'h0);
      @(posedge clk); #3;
      rst_n = 1'b1;
      step(1'b0, 1'b1, 4'hD, 1'b0, 4'h0);
      step(1'b0, 1'b1, 4'h1, 1'b0, 4'h0);
      chk("R9 held nibble cleared", {1'b0, rxdv_o, rxd_o}, 6'h0);
      step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule